// File: doc/BRIEF.md
# MDIO Management Master

This block is a memory-mapped master for the two-wire PHY management bus. Host software sets up a configuration word, a target address and a data word through a simple register bus. Writing an operation code then launches a single serial frame on the MDC clock and MDIO data pins. While the frame is on the wire a busy flag stays high. Software polls that flag, and once it drops a read result is waiting in the data register.

Two frame formats are handled. The direct format has start code 01 and a 5-bit register number. The indirect format has start code 00 and carries a device number in the same 5-bit field. For the indirect format, software first sends an address frame whose data field holds the register number. It then sends a write or read frame to that register. A 32-bit all-ones preamble can be switched on or off. The MDC rate comes from a divider, so that each half-period of MDC lasts (divider + 1) core clocks. The sampled input can be inverted for boards that invert the line.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset every register reads zero. Register selection uses bus address bits [3:2]: 0 = configuration, 1 = address, 2 = data, 3 = operation. The configuration register keeps bits [3:0] and the divider field [5+DIV_W-1:5], and reads 0 in every other bit. The address register keeps bits [9:0], with the PHY address in [9:5] and the register or device number in [4:0]. The data register keeps bits [15:0]. The operation register reads the last opcode in [1:0] and busy in bit 31.
- R2: A write to the operation register while idle and enabled starts a frame. Busy reads 1 from the clock after that write. Busy clears exactly 2·(P+32)·(D+1) core clocks after the launching edge, where P is 32 with the preamble enabled and 0 otherwise, and D is the divider.
- R3: With configuration bit 2 set, the frame starts with 32 ones. With the bit clear, no preamble is sent.
- R4: After the preamble the frame goes out MSB first: start code, then the opcode bits [1:0] as written, then the 5-bit PHY address, then the 5-bit register/device field. The start code is 01, or 00 when configuration bit 3 is set.
- R5: For opcodes 0 (address) and 1 (write) the master drives a turnaround of 1,0 and then data register bits [15:0].
- R6: For opcodes 2 and 3 (read) the master releases MDIO from the first turnaround bit onward. It samples 16 bits on the rising MDC edges, and they appear in data register [15:0] (upper bits 0) in the same cycle that busy clears.
- R7: MDC and the MDIO output enable are low whenever no frame is in progress.
- R8: With configuration bit 1 set, the sampled MDIO input is inverted before it is stored.
- R9: With configuration bit 0 clear, a write to the operation register starts no frame: busy stays 0 and MDC does not toggle.
- R10: Writes to the address, data and operation registers while busy is set are ignored and do not restart the frame.
- R11: During a frame, MDIO and its output enable change only on a falling MDC edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte offset of the selected register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data driven by the master |
| mdio_oe | output | 1 | Output enable for mdio_o |
| mdio_i | input | 1 | Management data seen on the line |

## Verification
The MDC half-period is D+1 cycles. The first rising edge comes D+1 cycles after the launching edge, and the final falling edge, which also clears busy and loads read data, comes 2·(P+32)·(D+1) cycles after it. The bench keeps a free-running cycle count. It records that count at the launching edge, polls busy on falling core-clock edges, and compares the exact elapsed count with the formula for divider values 0 through 3, with and without preamble. The PHY responder samples on rising MDC and drives on falling MDC, so read data is stable one full half-period before the master's sampling edge. Busy is expected to read 1 on the first falling core-clock edge after the launch. Writes made while busy, and an op write with the interface disabled, are checked by reading the registers back and by counting the frames the responder saw.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int FRAME_BITS = 32;
    localparam int PRE_BITS   = 32;
    localparam int CNT_W      = $clog2(FRAME_BITS + PRE_BITS);

    localparam int CFG_EN      = 0;
    localparam int CFG_INV     = 1;
    localparam int CFG_PRE     = 2;
    localparam int CFG_IND     = 3;
    localparam int CFG_DIV_LSB = 5;

    localparam logic [1:0] SEL_CFG  = 2'd0;
    localparam logic [1:0] SEL_ADDR = 2'd1;
    localparam logic [1:0] SEL_DATA = 2'd2;
    localparam logic [1:0] SEL_OP   = 2'd3;

    localparam logic [1:0] ST_DIRECT   = 2'b01;
    localparam logic [1:0] ST_INDIRECT = 2'b00;
    localparam logic [1:0] TA_DRIVE    = 2'b10;

    localparam int TA_FIRST_BIT = 17;
    localparam int DATA_MSB_BIT = 15;
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run || cnt_q == div) cnt_d = '0;
        else                      cnt_d = cnt_q + 1'b1;
    end

    assign tick = run && (cnt_q == div);

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [31:0] frame_word,
    input  logic        pre_en,
    input  logic        is_read,
    input  logic        tick,
    input  logic        mdio_in,
    output logic        active,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic        done,
    output logic [15:0] rd_data
);
    typedef struct packed {
        logic             active;
        logic             mdc;
        logic             rd;
        logic [CNT_W-1:0] cnt;
        logic [31:0]      frame;
        logic [15:0]      sh;
    } eng_t;

    eng_t q, d;
    logic in_pre, release_win, sample_win, cur_bit;

    assign in_pre      = q.cnt[CNT_W-1];
    assign release_win = q.rd && !in_pre && (q.cnt[4:0] <= 5'(TA_FIRST_BIT));
    assign sample_win  = q.rd && !in_pre && (q.cnt[4:0] <= 5'(DATA_MSB_BIT));
    assign cur_bit     = in_pre ? 1'b1 : q.frame[q.cnt[4:0]];

    always_comb begin
        d    = q;
        done = 1'b0;
        if (start) begin
            d.active = 1'b1;
            d.mdc    = 1'b0;
            d.rd     = is_read;
            d.cnt    = pre_en ? CNT_W'(FRAME_BITS + PRE_BITS - 1) : CNT_W'(FRAME_BITS - 1);
            d.frame  = frame_word;
            d.sh     = '0;
        end else if (q.active && tick) begin
            if (!q.mdc) begin
                d.mdc = 1'b1;
                if (sample_win) d.sh = {q.sh[14:0], mdio_in};
            end else begin
                d.mdc = 1'b0;
                if (q.cnt == '0) begin
                    d.active = 1'b0;
                    done     = 1'b1;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
        end
    end

    assign active  = q.active;
    assign mdc     = q.mdc;
    assign mdio_o  = q.active ? cur_bit : 1'b1;
    assign mdio_oe = q.active && !release_win;
    assign rd_data = q.sh;

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
    import mdio_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    localparam int CFG_W = CFG_DIV_LSB + DIV_W;

    typedef struct packed {
        logic [CFG_W-1:0] cfg;
        logic [9:0]       addr;
        logic [15:0]      data;
        logic [1:0]       op;
    } regs_t;

    regs_t regs_q, regs_d;
    logic [1:0]  sel;
    logic        op_wr, cfg_en, busy, start, done, tick;
    logic [9:0]  addr_q;
    logic [15:0] rd_data;
    logic [31:0] frame_word;
    logic [DIV_W-1:0] div;
    logic        unused_bits;

    assign sel        = reg_addr[3:2];
    assign op_wr      = reg_we && (sel == SEL_OP);
    assign cfg_en     = regs_q.cfg[CFG_EN];
    assign addr_q     = regs_q.addr;
    assign div        = regs_q.cfg[CFG_DIV_LSB +: DIV_W];
    assign start      = op_wr && !busy && cfg_en;
    assign unused_bits = ^{reg_addr, reg_wdata[31:16]};

    assign frame_word = {regs_q.cfg[CFG_IND] ? ST_INDIRECT : ST_DIRECT,
                         reg_wdata[1:0], regs_q.addr[9:5], regs_q.addr[4:0],
                         TA_DRIVE, regs_q.data};

    always_comb begin
        regs_d = regs_q;
        if (reg_we && sel == SEL_CFG) begin
            regs_d.cfg = '0;
            regs_d.cfg[CFG_IND:CFG_EN] = reg_wdata[CFG_IND:CFG_EN];
            regs_d.cfg[CFG_DIV_LSB +: DIV_W] = reg_wdata[CFG_DIV_LSB +: DIV_W];
        end
        if (!busy) begin
            if (reg_we && sel == SEL_ADDR) regs_d.addr = reg_wdata[9:0];
            if (reg_we && sel == SEL_DATA) regs_d.data = reg_wdata[15:0];
            if (op_wr)                     regs_d.op   = reg_wdata[1:0];
        end
        if (done && regs_q.op[1]) regs_d.data = rd_data;
    end

    always_comb begin
        unique case (sel)
            SEL_CFG:  reg_rdata = 32'(regs_q.cfg);
            SEL_ADDR: reg_rdata = {22'b0, regs_q.addr};
            SEL_DATA: reg_rdata = {16'b0, regs_q.data};
            default:  reg_rdata = {busy, 29'b0, regs_q.op};
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    mdio_clk_div #(.DIV_W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .div   (div),
        .tick  (tick)
    );

    mdio_frame_engine u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .frame_word (frame_word),
        .pre_en     (regs_q.cfg[CFG_PRE]),
        .is_read    (reg_wdata[1]),
        .tick       (tick),
        .mdio_in    (mdio_i ^ regs_q.cfg[CFG_INV]),
        .active     (busy),
        .mdc        (mdc),
        .mdio_o     (mdio_o),
        .mdio_oe    (mdio_oe),
        .done       (done),
        .rd_data    (rd_data)
    );
endmodule

// File: rtl/mdio_mgmt_master_chk.sv
module mdio_mgmt_master_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       op_wr,
    input logic       en,
    input logic       busy,
    input logic       mdc,
    input logic       mdio_o,
    input logic       mdio_oe,
    input logic [9:0] addr_q
);
    assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        op_wr && en && !busy |=> busy);

    assert_disabled_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        op_wr && !en && !busy |=> !busy);

    assert_idle_pins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc && !mdio_oe);

    assert_addr_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(addr_q));

    assert_mdio_on_fall_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) && !$fell(mdc) |-> $stable(mdio_o) && $stable(mdio_oe));
endmodule

bind mdio_mgmt_master mdio_mgmt_master_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_wr   (op_wr),
    .en      (cfg_en),
    .busy    (busy),
    .mdc     (mdc),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe),
    .addr_q  (addr_q)
);

// File: tb/tb_mdio_mgmt_master.sv
`timescale 1ns/1ps
module tb_mdio_mgmt_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe, mdio_i;
    logic        phy_oe = 1'b0, phy_bit = 1'b1, inv_line = 1'b0;
    logic        line;

    int vectors = 0, fails = 0, cyc = 0, t0 = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign line   = mdio_oe ? mdio_o : (phy_oe ? phy_bit : 1'b1);
    assign mdio_i = line ^ inv_line;

    mdio_mgmt_master dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // Behavioural PHY responder
    logic [15:0] dmem [32];
    logic [15:0] imem [16];
    logic [31:0] dflag = '0;
    logic [15:0] iflag = '0;
    logic [31:0] fr = '0;
    logic [15:0] rd_word = '0;
    logic [3:0]  ia = '0;
    logic        hunting = 1'b1, rd_frame = 1'b0;
    int          pos = 0, ones = 0, frames = 0, last_ones = 0;
    logic [31:0] last_fr = '0;

    function automatic logic [15:0] seed(input logic [4:0] r);
        return {r, 3'b101, r, 3'b010};
    endfunction

    always @(posedge mdc) begin
        if (hunting) begin
            if (line) ones++;
            else begin
                hunting = 1'b0;
                pos = 1;
                fr = {fr[30:0], 1'b0};
            end
        end else begin
            fr = {fr[30:0], line};
            pos++;
            if (pos == 14) begin
                rd_frame = fr[11];
                if (fr[13:12] == 2'b01)
                    rd_word = dflag[fr[4:0]] ? dmem[fr[4:0]] : seed(fr[4:0]);
                else
                    rd_word = iflag[ia] ? imem[ia] : seed({1'b1, ia});
            end
            if (pos == 32) begin
                if (fr[31:30] == 2'b01 && fr[29:28] == 2'b01) begin
                    dmem[fr[22:18]] = fr[15:0];
                    dflag[fr[22:18]] = 1'b1;
                end else if (fr[31:30] == 2'b00 && fr[29:28] == 2'b00) begin
                    ia = fr[3:0];
                end else if (fr[31:30] == 2'b00 && fr[29:28] == 2'b01) begin
                    imem[ia] = fr[15:0];
                    iflag[ia] = 1'b1;
                end
                last_fr = fr;
                last_ones = ones;
                ones = 0;
                frames++;
                hunting = 1'b1;
                rd_frame = 1'b0;
            end
        end
    end

    always @(negedge mdc) begin
        if (!hunting && rd_frame && pos == 15) begin
            phy_oe = 1'b1; phy_bit = 1'b0;
        end else if (!hunting && rd_frame && pos >= 16 && pos <= 31) begin
            phy_oe = 1'b1; phy_bit = rd_word[31-pos];
        end else begin
            phy_oe = 1'b0; phy_bit = 1'b1;
        end
    end

    // Bench helpers
    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic launch(input logic [1:0] op);
        logic [31:0] v;
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 4'hC; reg_wdata = {30'b0, op};
        @(posedge clk);
        t0 = cyc + 1;
        @(negedge clk);
        reg_we = 1'b0;
        rd(4'hC, v);
        chk("R2 busy after launch", {31'b0, v[31]}, 32'd1);
    endtask

    task automatic wait_idle(input int exp_len);
        logic [31:0] v;
        int guard = 0;
        do begin
            @(negedge clk);
            rd(4'hC, v);
            guard++;
        end while (v[31] && guard < 20000);
        chk("R2 frame length", cyc - t0, exp_len);
    endtask

    function automatic int flen(input bit pre, input int d);
        return 2 * (32 + (pre ? 32 : 0)) * (d + 1);
    endfunction

    // Scenarios
    task automatic t_reset();
        logic [31:0] v;
        for (int i = 0; i < 4; i++) begin
            rd(4'(i * 4), v);
            chk("R1 reset value", v, 32'd0);
        end
        chk("R7 idle mdc", {31'b0, mdc}, 0);
        chk("R7 idle oe", {31'b0, mdio_oe}, 0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        wr(4'h0, 32'hFFFF_FFFF);
        rd(4'h0, v); chk("R1 cfg mask", v, 32'h0000_1FEF);
        wr(4'h4, 32'hFFFF_FFFF);
        rd(4'h4, v); chk("R1 addr mask", v, 32'h0000_03FF);
        wr(4'h8, 32'hDEAD_BEEF);
        rd(4'h8, v); chk("R1 data mask", v, 32'h0000_BEEF);
        wr(4'h0, 32'h0);
    endtask

    task automatic t_direct_write();
        wr(4'h0, 32'h05);
        wr(4'h4, 32'h167);
        wr(4'h8, 32'hA5C3);
        launch(2'd1);
        wait_idle(flen(1, 0));
        chk("R3 preamble on", last_ones, 32);
        chk("R4 start direct", {30'b0, last_fr[31:30]}, 1);
        chk("R4 opcode", {30'b0, last_fr[29:28]}, 1);
        chk("R4 phy addr", {27'b0, last_fr[27:23]}, 32'h0B);
        chk("R4 reg num", {27'b0, last_fr[22:18]}, 32'h07);
        chk("R5 turnaround", {30'b0, last_fr[17:16]}, 2);
        chk("R5 write data", {16'b0, dmem[7]}, 32'hA5C3);
    endtask

    task automatic t_direct_read();
        logic [31:0] v;
        wr(4'h0, 32'h41);
        wr(4'h4, 32'h3F2);
        launch(2'd2);
        wait_idle(flen(0, 2));
        rd(4'h8, v);
        chk("R6 direct read data", v, {16'b0, seed(5'h12)});
        chk("R3 preamble off", last_ones, 0);
        chk("R4 read opcode", {30'b0, last_fr[29:28]}, 2);
    endtask

    task automatic t_indirect();
        logic [31:0] v;
        wr(4'h0, 32'h2D);
        wr(4'h4, 32'h061);
        wr(4'h8, 32'h0009);
        launch(2'd0);
        wait_idle(flen(1, 1));
        chk("R4 start indirect", {30'b0, last_fr[31:30]}, 0);
        chk("R5 address frame data", {16'b0, last_fr[15:0]}, 32'h0009);
        chk("R4 device num", {27'b0, last_fr[22:18]}, 1);
        wr(4'h8, 32'hBEEF);
        launch(2'd1);
        wait_idle(flen(1, 1));
        chk("R5 indirect write", {16'b0, imem[9]}, 32'hBEEF);
        wr(4'h8, 32'h0);
        launch(2'd3);
        wait_idle(flen(1, 1));
        rd(4'h8, v);
        chk("R6 indirect read data", v, 32'hBEEF);
        chk("R4 indirect read opcode", {30'b0, last_fr[29:28]}, 3);
    endtask

    task automatic t_invert();
        logic [31:0] v;
        wr(4'h0, 32'h03);
        wr(4'h4, 32'h005);
        inv_line = 1'b1;
        launch(2'd2);
        wait_idle(flen(0, 0));
        inv_line = 1'b0;
        rd(4'h8, v);
        chk("R8 inverted input", v, {16'b0, seed(5'h05)});
    endtask

    task automatic t_disabled();
        logic [31:0] v;
        int f0 = frames;
        wr(4'h0, 32'h04);
        wr(4'hC, 32'h1);
        rd(4'hC, v);
        chk("R9 no busy when disabled", {31'b0, v[31]}, 0);
        repeat (10) @(negedge clk);
        chk("R9 mdc quiet", {31'b0, mdc}, 0);
        chk("R9 no frame", frames - f0, 0);
    endtask

    task automatic t_busy_ignore();
        logic [31:0] v;
        int f0 = frames;
        wr(4'h0, 32'h61);
        wr(4'h4, 32'h0A1);
        wr(4'h8, 32'h1111);
        launch(2'd1);
        repeat (20) @(negedge clk);
        wr(4'h4, 32'h3FF);
        wr(4'h8, 32'hFFFF);
        wr(4'hC, 32'h2);
        rd(4'h4, v); chk("R10 addr ignored", v, 32'h0A1);
        rd(4'h8, v); chk("R10 data ignored", v, 32'h1111);
        rd(4'hC, v); chk("R10 op ignored", {30'b0, v[1:0]}, 1);
        wait_idle(flen(0, 3));
        chk("R10 one frame", frames - f0, 1);
        chk("R10 write data kept", {16'b0, dmem[1]}, 32'h1111);
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_direct_write();
        t_direct_read();
        t_indirect();
        t_invert();
        t_disabled();
        t_busy_ignore();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule